// File: doc/BRIEF.md
# Clock Divider with Selectable Source

This block derives one divided clock from a choice of parent clocks. It is set up through one 32-bit control register. The register holds a divide code, a halt flag and, when the block has more than one parent, a source index. The parents arrive as single-cycle tick strobes in the block's own clock domain. Each tick is one input clock period. The output is a registered level.

A parameter fixes the number of parents at one, four or eight. A validity mask marks which mux slots are wired. Software updates the register by read-modify-write. A register write reaches the running divider only at a period boundary, while the output is low. A high phase that is already under way therefore always finishes with the settings it started with.

The divide code is the ratio minus one. The halt flag forces the stored code to all ones. Clearing the halt flag loads the code written in the same access.

Top module: `clk_div_mux`

## Requirements
- R1: The ratio N runs from 1 to 64 and is written as N-1 in register bits 5:0.
- R2: For N of 2 or more, each output period spans N ticks of the selected source. The output is high for floor(N/2) of those ticks and low for the rest.
- R3: For N equal to 1, the output goes high for exactly the clock cycle after each tick of the selected source, and is low otherwise.
- R4: Setting the halt flag (bit 8) lets the current high phase finish. After that the output stays low.
- R5: A write with bit 8 set stores 0x3F in bits 5:0, whatever the written code. While halted, bits 5:0 read 0x3F.
- R6: A write that clears bit 8 restarts the output at the ratio given in bits 5:0 of that same write.
- R7: The source index is at bits 7:6 with four parents and at bits 14:12 with eight parents. With one parent there is no index field and source 0 is used.
- R8: A write that names a slot marked invalid leaves the stored source index unchanged. The output keeps running from the previous source.
- R9: New ratio, source or halt settings take effect only when a period completes with the output low. A high phase in progress keeps its length.
- R10: After reset the register reads 0x13F (halted, code 0x3F, source 0) and the output is low.
- R11: Register bits outside the code, halt and index fields read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| src_tick | input | NPAR | One tick strobe per parent clock |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value |
| clk_div_o | output | 1 | Divided output |

## Verification
Every ratio from 2 to 64 is run on source 0, which ticks every other cycle. This shows whether the high and low tick counts follow floor and ceiling, so odd ratios are told apart from even ones. A few ratios are repeated on sources that tick every third and every fifth cycle. The period in clock cycles then reveals which slot the mux actually uses, and an invalid-slot write must leave that period unchanged. Ratio 1 is checked cycle by cycle against the source strobe. Ratio changes and halt requests are issued just after a rising edge to show that the high phase in progress keeps its full length.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
    localparam int DIV_W    = 6;
    localparam int HALT_BIT = 8;

    function automatic int idx_width(input int nparents);
        return (nparents == 8) ? 3 : ((nparents == 4) ? 2 : 0);
    endfunction

    function automatic int idx_lsb(input int nparents);
        return (nparents == 8) ? 12 : 6;
    endfunction
endpackage

// File: rtl/clk_div_ctrl.sv
module clk_div_ctrl
    import clk_div_pkg::*;
#(
    parameter int              NPAR      = 4,
    parameter logic [NPAR-1:0] SRC_VALID = '1,
    parameter int              SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_div,
    input  logic             wr_halt,
    input  logic [SEL_W-1:0] wr_sel,
    output logic [DIV_W-1:0] cfg_div,
    output logic             cfg_halt,
    output logic [SEL_W-1:0] cfg_sel
);
    localparam int NSLOT = 2 ** SEL_W;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             halt;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    ctrl_t             ctrl_d, ctrl_q;
    logic [NSLOT-1:0]  valid_pad;
    logic              sel_ok;

    assign valid_pad = NSLOT'(SRC_VALID);

    always_comb begin
        ctrl_d = ctrl_q;
        sel_ok = (NPAR > 1) && valid_pad[wr_sel];
        if (wr_en) begin
            ctrl_d.halt = wr_halt;
            ctrl_d.div  = wr_halt ? '1 : wr_div;
            if (sel_ok) ctrl_d.sel = wr_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.div  <= '1;
            ctrl_q.halt <= 1'b1;
            ctrl_q.sel  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign cfg_div  = ctrl_q.div;
    assign cfg_halt = ctrl_q.halt;
    assign cfg_sel  = ctrl_q.sel;

    // Halted register always carries the all-ones code.
    assert_halt_code_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.halt |-> (ctrl_q.div == '1));

    // Stored index never points at an unwired slot.
    assert_sel_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_pad[ctrl_q.sel]);

    assert_bad_sel_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !valid_pad[wr_sel]) |=> $stable(ctrl_q.sel));
endmodule

// File: rtl/clk_div_core.sv
module clk_div_core
    import clk_div_pkg::*;
#(
    parameter int NPAR  = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPAR-1:0]  src_tick,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_halt,
    input  logic [SEL_W-1:0] cfg_sel,
    output logic             div_out
);
    localparam int NSLOT = 2 ** SEL_W;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             halt;
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] cnt;
        logic             out;
    } core_t;

    core_t            core_d, core_q;
    logic [NSLOT-1:0] tick_pad;
    logic             at_boundary;
    logic [DIV_W-1:0] eff_div;
    logic             eff_halt;
    logic [SEL_W-1:0] eff_sel;
    logic [DIV_W-1:0] cnt_nxt;
    logic [DIV_W:0]   hi_len;
    logic             tick;

    assign tick_pad = NSLOT'(src_tick);

    always_comb begin
        core_d      = core_q;
        at_boundary = (core_q.cnt == '0) && !core_q.out;
        eff_div     = at_boundary ? cfg_div  : core_q.div;
        eff_halt    = at_boundary ? cfg_halt : core_q.halt;
        eff_sel     = at_boundary ? cfg_sel  : core_q.sel;
        core_d.div  = eff_div;
        core_d.halt = eff_halt;
        core_d.sel  = eff_sel;
        tick        = tick_pad[eff_sel];
        hi_len      = ({1'b0, eff_div} + 1'b1) >> 1;
        cnt_nxt     = (core_q.cnt == eff_div) ? '0 : core_q.cnt + 1'b1;
        if (eff_halt) begin
            core_d.cnt = '0;
            core_d.out = 1'b0;
        end else if (eff_div == '0) begin
            core_d.cnt = '0;
            core_d.out = tick;
        end else if (tick) begin
            core_d.cnt = cnt_nxt;
            core_d.out = (cnt_nxt != '0) && ({1'b0, cnt_nxt} <= hi_len);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.div  <= '1;
            core_q.halt <= 1'b1;
            core_q.sel  <= '0;
            core_q.cnt  <= '0;
            core_q.out  <= 1'b0;
        end else begin
            core_q <= core_d;
        end
    end

    assign div_out = core_q.out;

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.cnt <= core_q.div);

    assert_halted_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.halt |-> !core_q.out);

    // Applied settings cannot move while the output is high.
    assert_cfg_frozen_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.out |=> $stable({core_q.div, core_q.halt, core_q.sel}));
endmodule

// File: rtl/clk_div_mux.sv
module clk_div_mux
    import clk_div_pkg::*;
#(
    parameter int              NPAR      = 4,
    parameter logic [NPAR-1:0] SRC_VALID = 4'b1011
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPAR-1:0] src_tick,
    input  logic            reg_we,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            clk_div_o
);
    localparam int FIELD_W = idx_width(NPAR);
    localparam int SEL_LSB = idx_lsb(NPAR);
    localparam int SEL_W   = (FIELD_W > 0) ? FIELD_W : 1;

    logic [DIV_W-1:0] cfg_div;
    logic             cfg_halt;
    logic [SEL_W-1:0] cfg_sel;
    logic [SEL_W-1:0] wr_sel;
    logic [31:0]      sel_bits;

    generate
        if (FIELD_W > 0) begin : g_sel_field
            assign wr_sel   = reg_wdata[SEL_LSB +: FIELD_W];
            assign sel_bits = 32'(cfg_sel) << SEL_LSB;
        end else begin : g_no_sel_field
            assign wr_sel   = '0;
            assign sel_bits = '0;
        end
    endgenerate

    clk_div_ctrl #(.NPAR(NPAR), .SRC_VALID(SRC_VALID), .SEL_W(SEL_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .wr_div   (reg_wdata[DIV_W-1:0]),
        .wr_halt  (reg_wdata[HALT_BIT]),
        .wr_sel   (wr_sel),
        .cfg_div  (cfg_div),
        .cfg_halt (cfg_halt),
        .cfg_sel  (cfg_sel)
    );

    clk_div_core #(.NPAR(NPAR), .SEL_W(SEL_W)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .cfg_div  (cfg_div),
        .cfg_halt (cfg_halt),
        .cfg_sel  (cfg_sel),
        .div_out  (clk_div_o)
    );

    assign reg_rdata = 32'(cfg_div) | (32'(cfg_halt) << HALT_BIT) | sel_bits;
endmodule

// File: tb/clk_div_mux_tb_top.sv
`timescale 1ns/1ps
module clk_div_mux_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_div_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    clk_div_mux dut_i (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_div_o(clk_div_o)
    );

    always #2.5 clk = ~clk;

    // Source tick spacing in cycles: slot0=2, slot1=3, slot2=1 (unwired), slot3=5
    initial forever begin
        @(posedge clk);
        #1;
        cyc = cyc + 1;
        src_tick[0] = (cyc % 2 == 0);
        src_tick[1] = (cyc % 3 == 0);
        src_tick[2] = 1'b1;
        src_tick[3] = (cyc % 5 == 0);
    end

    function automatic int period_of(input int s);
        case (s)
            0: return 2;
            1: return 3;
            2: return 1;
            default: return 5;
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_wdata = v;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic wait_rise(output bit ok);
        logic p;
        ok = 1'b0;
        @(negedge clk);
        p = clk_div_o;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!p && clk_div_o) begin ok = 1'b1; return; end
            p = clk_div_o;
        end
    endtask

    task automatic measure(input int s, output int hi, output int lo, output int cy);
        bit ok;
        logic p;
        hi = 0; lo = 0; cy = 0;
        wait_rise(ok); if (ok) wait_rise(ok); if (ok) wait_rise(ok);
        if (!ok) return;
        p = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            if (i > 0 && !p && clk_div_o) return;
            if (src_tick[s]) begin
                if (clk_div_o) hi++; else lo++;
            end
            cy++;
            p = clk_div_o;
            @(negedge clk);
        end
    endtask

    task automatic run_ratio(input string req, input int s, input int n);
        int hi, lo, cy;
        wr(32'((s & 3) << 6) | 32'(n - 1));
        measure(s, hi, lo, cy);
        chk({req, " high ticks"}, hi, n / 2);
        chk({req, " low ticks"}, lo, n - n / 2);
        chk({req, " period cycles"}, cy, n * period_of(s));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int hc;
        bit ok;
        logic pt;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 reset register", reg_rdata, 32'h13F);
        chk("R10 reset output", clk_div_o, 0);

        // R11: reserved bits read zero; all-ones write halts and selects slot 3
        wr(32'hFFFF_FFFF);
        @(negedge clk);
        chk("R11 all-ones write readback", reg_rdata, 32'h1FF);
        wr(32'hABCD_0041);
        @(negedge clk);
        chk("R11 reserved bits ignored", reg_rdata, 32'h41);

        // R1 R2: every ratio 2..64 on slot 0
        for (int n = 2; n <= 64; n++) run_ratio("R2 R1 sweep", 0, n);

        // R7: index at bits 7:6 picks the mux slot
        run_ratio("R7 slot1", 1, 5);
        run_ratio("R7 slot3", 3, 5);
        run_ratio("R7 slot3 even", 3, 6);

        // R8: unwired slot 2 is refused
        run_ratio("R8 before", 1, 4);
        wr(32'h0000_0083);
        @(negedge clk);
        chk("R8 index kept", reg_rdata, 32'h43);
        run_ratio("R8 after", 1, 4);

        // R3: ratio 1 follows slot 0 one cycle late
        wr(32'h0000_0000);
        repeat (10) @(negedge clk);
        pt = src_tick[0];
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk("R3 pass-through", clk_div_o, pt);
            pt = src_tick[0];
        end

        // R9: ratio change just after a rise keeps that high phase
        wr(32'h0000_0007);
        wait_rise(ok); wait_rise(ok);
        hc = 1;
        fork
            wr(32'h0000_0001);
            begin
                for (int i = 0; i < 200; i++) begin
                    @(negedge clk);
                    if (!clk_div_o) break;
                    hc++;
                end
            end
        join
        chk("R9 high phase length", hc, 8);
        run_ratio("R9 new ratio", 0, 2);

        // R4: halt just after a rise finishes that high phase then stays low
        wr(32'h0000_0007);
        wait_rise(ok); wait_rise(ok);
        hc = 1;
        fork
            wr(32'h0000_0107);
            begin
                for (int i = 0; i < 200; i++) begin
                    @(negedge clk);
                    if (!clk_div_o) break;
                    hc++;
                end
            end
        join
        chk("R4 last high phase", hc, 8);
        hc = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (clk_div_o) hc++;
        end
        chk("R4 stays low", hc, 0);

        // R5: halting write forces code to all ones
        @(negedge clk);
        chk("R5 halted readback", reg_rdata, 32'h13F);
        wr(32'h0000_0105);
        @(negedge clk);
        chk("R5 code forced", reg_rdata, 32'h13F);

        // R6: clearing halt applies the code of that write
        run_ratio("R6 restart", 0, 3);
        @(negedge clk);
        chk("R6 readback", reg_rdata, 32'h2);

        finish_run();
    end
endmodule